// File: doc/BRIEF.md
# DSP Load Address Generator

This block works out, in one combinational pass, the byte address a load should use and the value the pointer register should take afterwards. A single mode code picks one of eight addressing schemes: base plus a scaled signed offset, shifted index plus an absolute value, absolute with pointer set, and five post-update schemes in which the access uses the current pointer while the pointer moves on. The moves are by a modifier register, by a modifier with bit-reversed access addressing, by a small scaled immediate, and by a circular step that stays within a buffer. The circular step comes either from the immediate or from a count packed into the modifier.

Every access is either 2 or 4 bytes wide, and that size scales the immediate offsets and circular steps. In the circular schemes the buffer length sits in the low bits of the modifier register, and the buffer start comes from its own input, not from the pointer. The outputs feed the load port (`ea_o`) and the register file write port (`ptr_o` with `ptr_we_o`). The memory access itself and the formatting of the loaded data are handled elsewhere.

Top module: `dsp_ldaddr_gen`

## Requirements
- R1: Offset mode (`mode_i`=0): `ea_o` = `base_i` + sign-extended `ofs_i` (11 bits) times the access size, where `size4_i`=0 means 2 bytes and `size4_i`=1 means 4 bytes. `ptr_we_o`=0 and `ptr_o`=`base_i`.
- R2: Scaled-index mode (`mode_i`=1): `ea_o` = (`index_i` << `shamt_i`) + `abs_i`. `ptr_we_o`=0 and `ptr_o`=`base_i`.
- R3: Absolute-set mode (`mode_i`=2): `ea_o` and `ptr_o` both equal `abs_i`, and `ptr_we_o`=1.
- R4: Modifier post-update (`mode_i`=3): `ea_o`=`base_i` and `ptr_o`=`base_i`+`mod_i` (32-bit wrap, so a negative modifier moves backwards). `ptr_we_o`=1.
- R5: Bit-reversed post-update (`mode_i`=4): in `ea_o`, bits 15:0 are `base_i` bits 15:0 in reverse order and bits 31:16 are unchanged. `ptr_o`=`base_i`+`mod_i`. With a modifier of 0x2000 and a start at an aligned base, successive access offsets are 0, 4, 2, 6.
- R6: Immediate post-update (`mode_i`=5): `ea_o`=`base_i` and `ptr_o`=`base_i` + sign-extended `inc_i` (4 bits) times the access size.
- R7: Circular immediate (`mode_i`=6): `ea_o`=`base_i`. The step is sign-extended `inc_i` times the size, and the length is `mod_i`[16:0]. If the sum reaches start+length, length is subtracted. If a negative step takes it below start, length is added.
- R8: Circular register (`mode_i`=7): the step is `mod_i`[23:17], taken as a two's-complement count, times the size. The length is `mod_i`[16:0]. `inc_i` and `mod_i`[31:24] have no effect. Wrapping is the same as in R7.
- R9: In both circular modes the buffer start is `cstart_i`, not any part of the pointer.
- R10: `ptr_we_o` is 1 exactly for modes 2 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Addressing scheme code (0..7, see R1 to R8) |
| size4_i | input | 1 | Access size: 0 = 2 bytes, 1 = 4 bytes |
| base_i | input | 32 | Base register or current pointer |
| index_i | input | 32 | Index register for scaled-index mode |
| shamt_i | input | 2 | Index left shift amount |
| abs_i | input | 32 | Extended absolute value |
| ofs_i | input | 11 | Signed offset count for offset mode |
| inc_i | input | 4 | Signed post-increment count |
| mod_i | input | 32 | Modifier register (circular: count in 23:17, length in 16:0) |
| cstart_i | input | 32 | Circular buffer start address |
| ea_o | output | 32 | Effective access address |
| ptr_o | output | 32 | Updated pointer value |
| ptr_we_o | output | 1 | Pointer write enable |

## Verification
The block holds no state, so any fault shows up at the ports in the same evaluation as the inputs that exercise it. The one thing resembling state is the pointer as it moves through a sequence. The bench feeds `ptr_o` back into `base_i` across several steps, so a wrong wrap, a wrong reverse order or a mis-scaled step appears as a wrong address on the very next access of that walk. The walks run the circular modes over and under both buffer ends, and use a start that differs from the pointer's own alignment. That last case separates the start input from any bits taken off the pointer.

// File: rtl/dsp_ldaddr_pkg.sv
package dsp_ldaddr_pkg;

  typedef enum logic [2:0] {
    LA_OFFSET   = 3'd0,
    LA_SCIDX    = 3'd1,
    LA_ABSSET   = 3'd2,
    LA_POSTMOD  = 3'd3,
    LA_POSTBREV = 3'd4,
    LA_POSTIMM  = 3'd5,
    LA_CIRCIMM  = 3'd6,
    LA_CIRCREG  = 3'd7
  } la_mode_e;

endpackage

// File: rtl/dsp_ldaddr_scale.sv
module dsp_ldaddr_scale #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             size4_i,
  output logic [OUT_W-1:0] scaled_o
);

  localparam int unsigned PAD_W = OUT_W - IN_W;

  logic [OUT_W-1:0] ext;

  assign ext      = {{PAD_W{val_i[IN_W-1]}}, val_i};
  assign scaled_o = size4_i ? (ext << 2) : (ext << 1);

endmodule

// File: rtl/dsp_ldaddr_bitrev.sv
module dsp_ldaddr_bitrev #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REV_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign addr_o[i] = addr_i[REV_W-1-i];
  end

  assign addr_o[ADDR_W-1:REV_W] = addr_i[ADDR_W-1:REV_W];

endmodule

// File: rtl/dsp_ldaddr_circ.sv
module dsp_ldaddr_circ #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 17
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int unsigned EXT_W = ADDR_W + 1;
  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] len_x;
  logic [ADDR_W-1:0] sum;
  logic [EXT_W-1:0]  limit;
  logic              step_neg;

  assign len_x    = {{PAD_W{1'b0}}, len_i};
  assign sum      = ptr_i + step_i;
  assign limit    = {1'b0, start_i} + {1'b0, len_x};
  assign step_neg = step_i[ADDR_W-1];

  always_comb begin
    ptr_o = sum;
    if (!step_neg && ({1'b0, sum} >= limit)) begin
      ptr_o = sum - len_x;
    end else if (step_neg && (sum < start_i)) begin
      ptr_o = sum + len_x;
    end
  end

endmodule

// File: rtl/dsp_ldaddr_gen.sv
module dsp_ldaddr_gen #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFS_W   = 11,
  parameter int unsigned INC_W   = 4,
  parameter int unsigned SHAMT_W = 2,
  parameter int unsigned BREV_W  = 16,
  parameter int unsigned CLEN_W  = 17,
  parameter int unsigned CCNT_W  = 7
) (
  input  logic [2:0]         mode_i,
  input  logic               size4_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [ADDR_W-1:0]  abs_i,
  input  logic [OFS_W-1:0]   ofs_i,
  input  logic [INC_W-1:0]   inc_i,
  input  logic [ADDR_W-1:0]  mod_i,
  input  logic [ADDR_W-1:0]  cstart_i,
  output logic [ADDR_W-1:0]  ea_o,
  output logic [ADDR_W-1:0]  ptr_o,
  output logic               ptr_we_o
);

  import dsp_ldaddr_pkg::*;

  localparam int unsigned CCNT_LSB = CLEN_W;
  localparam int unsigned CCNT_MSB = CLEN_W + CCNT_W - 1;

  logic [ADDR_W-1:0] ofs_scaled;
  logic [ADDR_W-1:0] inc_scaled;
  logic [ADDR_W-1:0] cnt_scaled;
  logic [ADDR_W-1:0] brev_addr;
  logic [ADDR_W-1:0] circ_step;
  logic [ADDR_W-1:0] circ_ptr;
  logic [CLEN_W-1:0] circ_len;

  dsp_ldaddr_scale #(.IN_W(OFS_W), .OUT_W(ADDR_W)) u_ofs_scale (
    .val_i    (ofs_i),
    .size4_i  (size4_i),
    .scaled_o (ofs_scaled)
  );

  dsp_ldaddr_scale #(.IN_W(INC_W), .OUT_W(ADDR_W)) u_inc_scale (
    .val_i    (inc_i),
    .size4_i  (size4_i),
    .scaled_o (inc_scaled)
  );

  dsp_ldaddr_scale #(.IN_W(CCNT_W), .OUT_W(ADDR_W)) u_cnt_scale (
    .val_i    (mod_i[CCNT_MSB:CCNT_LSB]),
    .size4_i  (size4_i),
    .scaled_o (cnt_scaled)
  );

  dsp_ldaddr_bitrev #(.ADDR_W(ADDR_W), .REV_W(BREV_W)) u_bitrev (
    .addr_i (base_i),
    .addr_o (brev_addr)
  );

  assign circ_len  = mod_i[CLEN_W-1:0];
  assign circ_step = (mode_i == LA_CIRCREG) ? cnt_scaled : inc_scaled;

  dsp_ldaddr_circ #(.ADDR_W(ADDR_W), .LEN_W(CLEN_W)) u_circ (
    .ptr_i   (base_i),
    .step_i  (circ_step),
    .start_i (cstart_i),
    .len_i   (circ_len),
    .ptr_o   (circ_ptr)
  );

  always_comb begin
    ea_o     = base_i;
    ptr_o    = base_i;
    ptr_we_o = 1'b1;
    case (mode_i)
      LA_OFFSET: begin
        ea_o     = base_i + ofs_scaled;
        ptr_we_o = 1'b0;
      end
      LA_SCIDX: begin
        ea_o     = (index_i << shamt_i) + abs_i;
        ptr_we_o = 1'b0;
      end
      LA_ABSSET: begin
        ea_o  = abs_i;
        ptr_o = abs_i;
      end
      LA_POSTMOD: begin
        ptr_o = base_i + mod_i;
      end
      LA_POSTBREV: begin
        ea_o  = brev_addr;
        ptr_o = base_i + mod_i;
      end
      LA_POSTIMM: begin
        ptr_o = base_i + inc_scaled;
      end
      default: begin
        ptr_o = circ_ptr;
      end
    endcase
  end

endmodule

// File: rtl/dsp_ldaddr_gen_chk.sv
module dsp_ldaddr_gen_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFS_W   = 11,
  parameter int unsigned INC_W   = 4,
  parameter int unsigned SHAMT_W = 2,
  parameter int unsigned BREV_W  = 16,
  parameter int unsigned CLEN_W  = 17,
  parameter int unsigned CCNT_W  = 7
) (
  input logic [2:0]         mode_i,
  input logic               size4_i,
  input logic [ADDR_W-1:0]  base_i,
  input logic [ADDR_W-1:0]  index_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [ADDR_W-1:0]  abs_i,
  input logic [OFS_W-1:0]   ofs_i,
  input logic [INC_W-1:0]   inc_i,
  input logic [ADDR_W-1:0]  mod_i,
  input logic [ADDR_W-1:0]  cstart_i,
  input logic [ADDR_W-1:0]  ea_o,
  input logic [ADDR_W-1:0]  ptr_o,
  input logic               ptr_we_o
);

  localparam int unsigned PAD_W   = ADDR_W - CLEN_W;
  localparam int unsigned SAFE_LEN = 256;

  logic            known;
  logic [ADDR_W:0] lim;
  logic            in_buf;
  logic            big_buf;

  always_comb begin
    known   = !$isunknown({mode_i, size4_i, base_i, index_i, shamt_i, abs_i,
                           ofs_i, inc_i, mod_i, cstart_i, ea_o, ptr_o, ptr_we_o});
    lim     = {1'b0, cstart_i} + {1'b0, {PAD_W{1'b0}}, mod_i[CLEN_W-1:0]};
    in_buf  = (base_i >= cstart_i) && ({1'b0, base_i} < lim);
    big_buf = mod_i[CLEN_W-1:0] >= CLEN_W'(SAFE_LEN);
    if (known) begin
      if (mode_i <= 3'd1) begin
        AST_NO_WB_LOCAL: assert (!ptr_we_o && ptr_o == base_i); // R1
      end
      if (mode_i == 3'd2) begin
        AST_ABS_SETS_BOTH: assert (ptr_we_o && ea_o == abs_i && ptr_o == abs_i); // R3
      end
      if (mode_i >= 3'd3 && mode_i != 3'd4) begin
        AST_POST_USES_PTR: assert (ptr_we_o && ea_o == base_i); // R4
      end
      if (mode_i == 3'd3 || mode_i == 3'd4) begin
        AST_MOD_ADVANCE: assert (ptr_o == base_i + mod_i); // R4
      end
      if (mode_i == 3'd4) begin
        AST_BREV_UPPER_KEEP: assert (ea_o[ADDR_W-1:BREV_W] == base_i[ADDR_W-1:BREV_W] && ea_o[0] == base_i[BREV_W-1] && ea_o[BREV_W-1] == base_i[0]); // R5
      end
      if (mode_i >= 3'd6 && in_buf && big_buf) begin
        AST_CIRC_IN_RANGE: assert (ptr_o >= cstart_i && {1'b0, ptr_o} < lim); // R7
      end
    end
  end

endmodule

bind dsp_ldaddr_gen dsp_ldaddr_gen_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .INC_W(INC_W), .SHAMT_W(SHAMT_W),
  .BREV_W(BREV_W), .CLEN_W(CLEN_W), .CCNT_W(CCNT_W)
) u_chk (.*);

// File: tb/dsp_ldaddr_gen_test.sv
module dsp_ldaddr_gen_test;

  localparam logic [31:0] B = 32'h0001_0000;

  logic        clk;
  logic [2:0]  mode_i;
  logic        size4_i;
  logic [31:0] base_i, index_i, abs_i, mod_i, cstart_i;
  logic [1:0]  shamt_i;
  logic [10:0] ofs_i;
  logic [3:0]  inc_i;
  logic [31:0] ea_o, ptr_o;
  logic        ptr_we_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dsp_ldaddr_gen uut (
    .mode_i(mode_i), .size4_i(size4_i), .base_i(base_i), .index_i(index_i),
    .shamt_i(shamt_i), .abs_i(abs_i), .ofs_i(ofs_i), .inc_i(inc_i),
    .mod_i(mod_i), .cstart_i(cstart_i), .ea_o(ea_o), .ptr_o(ptr_o),
    .ptr_we_o(ptr_we_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    mode_i = 3'd0; size4_i = 1'b0; base_i = '0; index_i = '0; abs_i = '0;
    mod_i = '0; cstart_i = '0; shamt_i = '0; ofs_i = '0; inc_i = '0;
  endtask

  task automatic t_idle();
    clear_inputs();
    settle();
    chk("R1 idle ea", ea_o, 32'h0);
    chk("R1 idle ptr", ptr_o, 32'h0);
    chk("R10 idle we", {31'b0, ptr_we_o}, 32'h0);
  endtask

  task automatic t_offset();
    clear_inputs();
    base_i = B;
    for (int k = 0; k < 4; k++) begin
      ofs_i = 11'(k);
      settle();
      chk("R1 ofs size2 ea", ea_o, B + 32'(2 * k));
      chk("R1 ofs we", {31'b0, ptr_we_o}, 32'h0);
      chk("R1 ofs ptr", ptr_o, B);
    end
    size4_i = 1'b1; ofs_i = 11'd3;
    settle();
    chk("R1 ofs size4 ea", ea_o, B + 32'd12);
    ofs_i = 11'h7FF;
    settle();
    chk("R1 ofs neg size4", ea_o, 32'h0000_FFFC);
    size4_i = 1'b0; ofs_i = 11'h400;
    settle();
    chk("R1 ofs min size2", ea_o, 32'h0000_F800);
  endtask

  task automatic t_index();
    clear_inputs();
    mode_i = 3'd1; abs_i = B; shamt_i = 2'd1; base_i = 32'h0000_0777;
    for (int k = 0; k < 4; k++) begin
      index_i = 32'(k);
      settle();
      chk("R2 idx shift1", ea_o, B + 32'(2 * k));
      chk("R2 idx ptr", ptr_o, 32'h0000_0777);
    end
    shamt_i = 2'd2; index_i = 32'd3;
    settle();
    chk("R2 idx shift2", ea_o, B + 32'd12);
    chk("R10 idx we", {31'b0, ptr_we_o}, 32'h0);
    shamt_i = 2'd0; index_i = 32'd5;
    settle();
    chk("R2 idx shift0", ea_o, B + 32'd5);
  endtask

  task automatic t_abs();
    clear_inputs();
    mode_i = 3'd2; abs_i = B + 32'd8; base_i = 32'hDEAD_0000;
    settle();
    chk("R3 abs ea", ea_o, B + 32'd8);
    chk("R3 abs ptr", ptr_o, B + 32'd8);
    chk("R10 abs we", {31'b0, ptr_we_o}, 32'h1);
    abs_i = 32'h1234_5678;
    settle();
    chk("R3 abs ea2", ea_o, 32'h1234_5678);
    chk("R3 abs ptr2", ptr_o, 32'h1234_5678);
  endtask

  task automatic t_postmod();
    clear_inputs();
    mode_i = 3'd3; base_i = B; mod_i = 32'd2;
    for (int k = 0; k < 4; k++) begin
      settle();
      chk("R4 pm ea", ea_o, B + 32'(2 * k));
      chk("R4 pm ptr", ptr_o, B + 32'(2 * (k + 1)));
      chk("R10 pm we", {31'b0, ptr_we_o}, 32'h1);
      base_i = ptr_o;
    end
    base_i = B + 32'd8; mod_i = 32'hFFFF_FFFC;
    settle();
    chk("R4 pm neg ptr", ptr_o, B + 32'd4);
  endtask

  task automatic t_brev();
    logic [31:0] offs [4];
    offs[0] = 32'd0; offs[1] = 32'd4; offs[2] = 32'd2; offs[3] = 32'd6;
    clear_inputs();
    mode_i = 3'd4; base_i = B; mod_i = 32'h0000_2000;
    for (int k = 0; k < 4; k++) begin
      settle();
      chk("R5 brev ea", ea_o, B + offs[k]);
      chk("R5 brev ptr", ptr_o, B + 32'h2000 * 32'(k + 1));
      chk("R10 brev we", {31'b0, ptr_we_o}, 32'h1);
      base_i = ptr_o;
    end
    base_i = 32'h0005_0001; mod_i = 32'd0;
    settle();
    chk("R5 brev low bit", ea_o, 32'h0005_8000);
    base_i = 32'h0003_C002;
    settle();
    chk("R5 brev mixed", ea_o, 32'h0003_4003);
  endtask

  task automatic t_postimm();
    clear_inputs();
    mode_i = 3'd5; base_i = B; inc_i = 4'd1;
    for (int k = 0; k < 3; k++) begin
      settle();
      chk("R6 pi ea", ea_o, B + 32'(2 * k));
      chk("R6 pi ptr", ptr_o, B + 32'(2 * (k + 1)));
      base_i = ptr_o;
    end
    size4_i = 1'b1; inc_i = 4'hD; base_i = B + 32'd40;
    settle();
    chk("R6 pi neg size4", ptr_o, B + 32'd28);
    inc_i = 4'd7;
    settle();
    chk("R6 pi max size4", ptr_o, B + 32'd68);
  endtask

  task automatic t_circimm();
    logic [31:0] nxt [4];
    nxt[0] = 32'd2; nxt[1] = 32'd4; nxt[2] = 32'd0; nxt[3] = 32'd2;
    clear_inputs();
    mode_i = 3'd6; cstart_i = B; base_i = B; mod_i = 32'd6; inc_i = 4'd1;
    for (int k = 0; k < 4; k++) begin
      settle();
      chk("R7 ci ea", ea_o, (k == 0) ? B : B + nxt[k - 1]);
      chk("R7 ci ptr", ptr_o, B + nxt[k]);
      chk("R10 ci we", {31'b0, ptr_we_o}, 32'h1);
      base_i = ptr_o;
    end
    base_i = B; inc_i = 4'hF;
    settle();
    chk("R7 ci under wrap", ptr_o, B + 32'd4);
    base_i = B + 32'd2;
    settle();
    chk("R7 ci neg no wrap", ptr_o, B);
    size4_i = 1'b1; inc_i = 4'd1; mod_i = 32'd8; base_i = B + 32'd4;
    settle();
    chk("R7 ci size4 wrap", ptr_o, B);
    cstart_i = B + 32'h100; base_i = B + 32'h104;
    settle();
    chk("R9 ci own start", ptr_o, B + 32'h100);
    cstart_i = B + 32'h0FC; base_i = B + 32'h100;
    settle();
    chk("R9 ci start unaligned", ptr_o, B + 32'h0FC);
  endtask

  task automatic t_circreg();
    clear_inputs();
    mode_i = 3'd7; cstart_i = B; base_i = B; inc_i = 4'd7;
    mod_i = 32'hAB04_0008;
    for (int k = 0; k < 4; k++) begin
      settle();
      chk("R8 cr ea", ea_o, (k % 2 == 0) ? B : B + 32'd4);
      chk("R8 cr ptr", ptr_o, (k % 2 == 0) ? B + 32'd4 : B);
      chk("R10 cr we", {31'b0, ptr_we_o}, 32'h1);
      base_i = ptr_o;
    end
    size4_i = 1'b1; mod_i = 32'h0002_0008; base_i = B + 32'd4;
    settle();
    chk("R8 cr size4 wrap", ptr_o, B);
    size4_i = 1'b0; mod_i = 32'h00FE_0008; base_i = B;
    settle();
    chk("R8 cr neg count", ptr_o, B + 32'd6);
    cstart_i = B + 32'h40; base_i = B + 32'h44; mod_i = 32'h0004_0008;
    settle();
    chk("R9 cr own start", ptr_o, B + 32'h40);
  endtask

  initial begin
    clear_inputs();
    t_idle();
    t_offset();
    t_index();
    t_abs();
    t_postmod();
    t_brev();
    t_postimm();
    t_circimm();
    t_circreg();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule